// File: doc/BRIEF.md
# Double-Buffered SPI Master with Status Flags

This block is an SPI master for a small CPU register bus. A one-byte holding register sits in front of the shift register. Software can therefore queue the next byte while the current one is still being clocked out, and consecutive bytes leave with no pause in the serial clock. Each byte that comes in is copied into a receive register and a receive-full flag is raised.

The receive-full flag has a two-step release. It is cleared by a status read that sees the flag set, followed by a data read. The overrun and mode-fault flags follow a similar handshake. Two interrupt lines are derived from the flags: one for the transmit side and one for receive-or-error.

Three further features are included:
- Clock polarity and phase are selectable.
- A repeat option keeps the link running when nothing is queued. It resends whatever the shift register last held.
- A low level on the slave-select input while the master is enabled raises a mode fault and switches the block off.

Top module: `spi_dbl_ctrl`

## Requirements
- R1: A bus write to address 0 loads the holding register and clears the transmit-empty flag (status bit 1). When the shifter is idle and the block is enabled, the queued byte moves into the shift register on the next clock edge and transmit-empty is set again. This is at most two cycles after the write.
- R2: A byte queued while another is shifting starts on the edge that ends the previous byte. For 3 bytes queued back to back with CPOL=0 and CPHA=1, the serial clock makes exactly 48 transitions, never more than CLK_DIV cycles apart.
- R3: Bytes go out MSB first on `mosi_o`, with 8 bits per byte and each half-period lasting CLK_DIV cycles.
  - When idle, `sck_o` equals CPOL (control bit 1).
  - With CPHA (control bit 2) at 0, the clock first sits at CPOL for half a period and then toggles.
  - With CPHA at 1, the clock leaves CPOL at the start of the byte.
  - `miso_i` is sampled at the end of each bit's first half-period.
  - Shifting requires the enable bit.
- R4: When a byte completes and the receive-full flag (status bit 0) is clear, the received byte is stored in the receive register, read at address 0, and receive-full is set.
- R5: Receive-full clears only when a read of status (address 2) that sees it set is followed by a read of address 0. A data read without that preceding status read leaves it set.
- R6: A byte that completes while receive-full is set raises overrun (status bit 2) and leaves the receive register unchanged. Overrun clears through the same status-read then data-read sequence.
- R7: With repeat (control bit 6) set and nothing queued, a new transfer starts anyway and resends the shift register's last content. With a loopback, that is the byte just received.
- R8: While enabled, a synchronised low on `ss_n_i` sets mode-fault (status bit 3), clears enable (control bit 0) and aborts a transfer.
  - While mode-fault is set, enable cannot be set.
  - A status read that sees mode-fault, followed by a control write, clears it. That same write may set enable.
- R9: `irq_tx` is high exactly when enable, transmit-empty and the transmit interrupt enable (control bit 3) are all set.
- R10: `irq_rxe` is high when receive-full is set with the receive interrupt enable (control bit 4) set. It is also high when overrun or mode-fault is set with the error interrupt enable (control bit 5) set.
- R11: After reset:
  - the status register reads 0x02;
  - the control register reads 0x00;
  - `sck_o` is low;
  - both interrupt lines are low.
- R12: Address 1 reads back the control bits written to it (bits 6 to 0). Address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe (reads have side effects on flags) |
| addr | input | 2 | Register select: 0 data, 1 control, 2 status |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for the selected register |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_n_i | input | 1 | Slave-select sense; low while enabled is a mode fault |
| irq_tx | output | 1 | Transmitter interrupt request |
| irq_rxe | output | 1 | Receiver or error interrupt request |

## Verification
The bench builds the block with the defaults CLK_DIV=2 and DW=8. A byte therefore lasts only 32 cycles, so status polls, data reads and queued writes land inside individual bytes and right on byte boundaries. With `mosi_o` looped back to `miso_i`, every received byte is known in advance. This makes overrun, the repeat option and the two-step flag release observable in a few hundred cycles. Both clock phases and both polarities are used across the scenarios.

// File: rtl/spi_dbl_ctrl.sv
module spi_dbl_ctrl #(
  parameter int CLK_DIV = 2,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          sck_o,
  output logic          mosi_o,
  input  logic          miso_i,
  input  logic          ss_n_i,
  output logic          irq_tx,
  output logic          irq_rxe
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int HW = $clog2(2 * DW);
  localparam logic [CW-1:0] CNT_TOP = CW'(CLK_DIV - 1);
  localparam logic [HW-1:0] HALF_TOP = HW'(2 * DW - 1);

  logic en, cpol, cpha, txie, rxie, erie, rpt;
  logic [DW-1:0] txbuf, sh, rxbuf;
  logic tx_empty, rx_full, ovf, modf, rx_arm, ovf_arm, modf_arm;
  logic busy, rbit;
  logic [CW-1:0] cnt;
  logic [HW-1:0] half;
  logic [1:0] ss_q;

  wire wr_data = wr_en && addr == 2'd0;
  wire wr_ctrl = wr_en && addr == 2'd1;
  wire rd_data = rd_en && addr == 2'd0;
  wire rd_stat = rd_en && addr == 2'd2;
  wire mf_hit  = en && !ss_q[1];
  wire run     = en && !mf_hit;
  wire tick    = busy && cnt == CNT_TOP;
  wire done    = run && tick && half == HALF_TOP;
  wire go      = run && (!tx_empty || rpt) && (!busy || done);
  wire load    = go && !tx_empty;
  wire rx_clr  = rd_data && rx_arm;
  wire ovf_clr = rd_data && ovf_arm;
  wire [DW-1:0] rx_word = {sh[DW-2:0], rbit};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      half <= '0;
      sh   <= '0;
      rbit <= 1'b0;
    end else if (!run) begin
      busy <= 1'b0;
    end else begin
      if (busy) begin
        cnt <= tick ? '0 : cnt + CW'(1);
        if (tick) begin
          half <= half + HW'(1);
          if (!half[0]) rbit <= miso_i;
          else          sh   <= rx_word;
        end
      end
      if (done) busy <= 1'b0;
      if (go) begin
        busy <= 1'b1;
        cnt  <= '0;
        half <= '0;
        if (load) sh <= txbuf;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {en, cpol, cpha, txie, rxie, erie, rpt} <= '0;
      txbuf <= '0;
      rxbuf <= '0;
      tx_empty <= 1'b1;
      {rx_full, ovf, modf, rx_arm, ovf_arm, modf_arm} <= '0;
      ss_q <= 2'b11;
    end else begin
      if (load) tx_empty <= 1'b1;
      if (wr_data) begin
        txbuf    <= wdata;
        tx_empty <= 1'b0;
      end
      if (rx_clr)  rx_full <= 1'b0;
      if (ovf_clr) ovf <= 1'b0;
      if (done) begin
        if (rx_full && !rx_clr) ovf <= 1'b1;
        else begin
          rxbuf   <= rx_word;
          rx_full <= 1'b1;
        end
      end
      if (rd_stat && rx_full) rx_arm <= 1'b1;
      if (rx_clr) rx_arm <= 1'b0;
      if (rd_stat && ovf) ovf_arm <= 1'b1;
      if (ovf_clr) ovf_arm <= 1'b0;
      if (wr_ctrl) begin
        {rpt, erie, rxie, txie, cpha, cpol} <= wdata[6:1];
        en <= wdata[0] && !(modf && !modf_arm);
        if (modf_arm) begin
          modf     <= 1'b0;
          modf_arm <= 1'b0;
        end
      end
      if (rd_stat && modf) modf_arm <= 1'b1;
      if (mf_hit) begin
        en   <= 1'b0;
        modf <= 1'b1;
      end
      ss_q <= {ss_q[0], ss_n_i};
    end

  assign sck_o   = busy ? (cpol ^ (cpha ? ~half[0] : half[0])) : cpol;
  assign mosi_o  = sh[DW-1];
  assign irq_tx  = en & tx_empty & txie;
  assign irq_rxe = (rx_full & rxie) | ((modf | ovf) & erie);

  always_comb
    case (addr)
      2'd0:    rdata = rxbuf;
      2'd1:    rdata = {{(DW-7){1'b0}}, rpt, erie, rxie, txie, cpha, cpol, en};
      2'd2:    rdata = {{(DW-4){1'b0}}, modf, ovf, tx_empty, rx_full};
      default: rdata = '0;
    endcase
endmodule

// File: rtl/spi_dbl_ctrl_chk.sv
module spi_dbl_ctrl_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic [1:0]    addr,
  input logic          en,
  input logic          tx_empty,
  input logic          rx_full,
  input logic          modf,
  input logic          busy,
  input logic          done,
  input logic          ss_s,
  input logic          irq_tx,
  input logic [DW-1:0] rxbuf
);
  AST_WRITE_CLEARS_TXE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == 2'd0 |=> !tx_empty); // R1
  AST_TXE_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
    en && ss_s && !tx_empty && !busy && !(wr_en && addr == 2'd0) |=> tx_empty); // R1
  AST_WRITE_DROPS_TXIRQ: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == 2'd0 |=> !irq_tx); // R9
  AST_RXF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full && !(rd_en && addr == 2'd0) |=> rx_full); // R5
  AST_RXBUF_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full && !(rd_en && addr == 2'd0) |=> $stable(rxbuf)); // R6
  AST_DONE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> rx_full); // R4
  AST_MODF_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    en && !ss_s |=> !en && modf); // R8
  AST_SHIFT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $past(en)); // R3
endmodule

bind spi_dbl_ctrl spi_dbl_ctrl_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .en(en), .tx_empty(tx_empty), .rx_full(rx_full), .modf(modf),
  .busy(busy), .done(done), .ss_s(ss_q[1]), .irq_tx(irq_tx), .rxbuf(rxbuf)
);

// File: tb/spi_dbl_ctrl_tb_top.sv
`timescale 1ns/100ps
module spi_dbl_ctrl_tb_top;
  localparam int D = 2;
  localparam int NB = 16 * D;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, ss_n = 1'b1;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic sck, mosi, irq_tx, irq_rxe;

  always #2.5 clk = ~clk;

  spi_dbl_ctrl #(.CLK_DIV(D), .DW(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .sck_o(sck), .mosi_o(mosi), .miso_i(mosi),
    .ss_n_i(ss_n), .irq_tx(irq_tx), .irq_rxe(irq_rxe)
  );

  int tests = 0, fails = 0;

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  bit m_en, m_cpol, m_cpha, m_txie, m_rxie, m_erie, m_rpt;
  bit m_rxf, m_ovf, m_modf, a_rx, a_ovf, a_modf;
  bit m_ss1 = 1'b1, m_ss2 = 1'b1;
  byte unsigned m_txq[$];
  byte unsigned m_cur, m_rx;
  int m_t = -1;

  always @(posedge clk or negedge rst_n) begin : model
    bit rs, rdd, wd, wc, hit, fin, rxc, ovc, st, o_rxf, o_ovf, o_modf, o_am;
    if (!rst_n) begin
      {m_en, m_cpol, m_cpha, m_txie, m_rxie, m_erie, m_rpt} = '0;
      {m_rxf, m_ovf, m_modf, a_rx, a_ovf, a_modf} = '0;
      m_ss1 = 1'b1; m_ss2 = 1'b1;
      m_txq.delete();
      m_cur = 0; m_rx = 0; m_t = -1;
    end else begin
      rs  = rd_en && addr == 2'd2;
      rdd = rd_en && addr == 2'd0;
      wd  = wr_en && addr == 2'd0;
      wc  = wr_en && addr == 2'd1;
      hit = m_en && !m_ss2;
      fin = m_en && !hit && m_t == NB - 1;
      rxc = rdd && a_rx;
      ovc = rdd && a_ovf;
      st  = m_en && !hit && (m_txq.size() > 0 || m_rpt) && (m_t < 0 || fin);
      o_rxf = m_rxf; o_ovf = m_ovf; o_modf = m_modf; o_am = a_modf;
      if (rxc) m_rxf = 0;
      if (ovc) m_ovf = 0;
      if (fin) begin
        if (o_rxf && !rxc) m_ovf = 1;
        else begin m_rx = m_cur; m_rxf = 1; end
      end
      if (rs && o_rxf) a_rx = 1;
      if (rxc) a_rx = 0;
      if (rs && o_ovf) a_ovf = 1;
      if (ovc) a_ovf = 0;
      if (!m_en || hit) m_t = -1;
      else if (st) begin
        m_t = 0;
        if (m_txq.size() > 0) m_cur = m_txq.pop_front();
      end else if (m_t >= 0) m_t = fin ? -1 : m_t + 1;
      if (wd) begin m_txq.delete(); m_txq.push_back(wdata); end
      if (wc) begin
        {m_rpt, m_erie, m_rxie, m_txie, m_cpha, m_cpol} = wdata[6:1];
        m_en = wdata[0] && !(o_modf && !o_am);
        if (o_am) begin m_modf = 0; a_modf = 0; end
      end
      if (rs && o_modf) a_modf = 1;
      if (hit) begin m_en = 0; m_modf = 1; end
      m_ss2 = m_ss1; m_ss1 = ss_n;
    end
  end

  bit meas = 0;
  int tog = 0, since = 0, maxg = 0;
  logic prv = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      bit exp_sck;
      exp_sck = (m_t < 0) ? m_cpol
              : m_cpol ^ (m_cpha ? ((m_t / D) % 2 == 0) : ((m_t / D) % 2 == 1));
      chk("R3 sck level", sck, exp_sck);
      if (m_t >= 0) chk("R3 R7 mosi bit", mosi, m_cur[7 - m_t / (2 * D)]);
      chk("R9 irq_tx", irq_tx, m_en && m_txq.size() == 0 && m_txie);
      chk("R10 irq_rxe", irq_rxe, (m_rxf && m_rxie) || ((m_ovf || m_modf) && m_erie));
      if (rd_en) begin
        case (addr)
          2'd0: chk("R12 data read", rdata, m_rx);
          2'd1: chk("R12 control read", rdata,
                    {1'b0, m_rpt, m_erie, m_rxie, m_txie, m_cpha, m_cpol, m_en});
          2'd2: chk("R12 status read", rdata,
                    {4'b0, m_modf, m_ovf, m_txq.size() == 0, m_rxf});
          default: chk("R12 spare read", rdata, 0);
        endcase
      end
    end
    if (meas) begin
      if (sck !== prv) begin
        tog++;
        if (tog > 1 && since + 1 > maxg) maxg = since + 1;
        since = 0;
      end else since++;
    end
    prv = sck;
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk) d = rdata;
    cyc();
    rd_en = 1'b0;
  endtask

  task automatic wait_idle();
    while (m_t >= 0 || m_txq.size() > 0) cyc();
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] s, d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cyc(); cyc();
    // R11 reset state
    bus_rd(2'd2, s); chk("R11 status after reset", s, 8'h02);
    bus_rd(2'd1, s); chk("R11 control after reset", s, 8'h00);
    chk("R11 sck idle", sck, 0);
    chk("R11 irq_tx", irq_tx, 0);
    chk("R11 irq_rxe", irq_rxe, 0);
    // R12 control readback
    bus_wr(2'd1, 8'h7E);
    bus_rd(2'd1, s); chk("R12 control readback", s, 8'h7E);
    bus_rd(2'd3, s); chk("R12 spare address", s, 8'h00);
    bus_wr(2'd1, 8'h00);
    // R1 R2 R4 R5: three bytes, CPOL=0 CPHA=1
    bus_wr(2'd1, 8'h0D);
    meas = 1;
    bus_wr(2'd0, 8'hA5);
    @(negedge clk); chk("R1 write clears tx-empty", irq_tx, 0);
    @(negedge clk); chk("R1 tx-empty back within two cycles", irq_tx, 1);
    cyc();
    bus_wr(2'd0, 8'h3C);
    while (!irq_tx) cyc();
    bus_wr(2'd0, 8'h96);
    do bus_rd(2'd2, s); while (!s[0]);
    bus_rd(2'd0, d); chk("R4 first byte received", d, 8'hA5);
    while (!m_rxf) cyc();
    bus_rd(2'd0, d);
    bus_rd(2'd2, s); chk("R5 data read alone keeps rx-full", s[0], 1);
    bus_rd(2'd0, d); chk("R4 second byte received", d, 8'h3C);
    bus_rd(2'd2, s); chk("R5 rx-full cleared by sequence", s[0], 0);
    wait_idle();
    bus_rd(2'd2, s); chk("R4 third byte flagged", s[0], 1);
    bus_rd(2'd0, d); chk("R4 third byte received", d, 8'h96);
    meas = 0;
    chk("R2 clock transitions for three bytes", tog, 48);
    chk("R2 largest gap between transitions", maxg, D);
    // R6 overrun, CPHA=1, all interrupts enabled
    bus_wr(2'd1, 8'h3D);
    bus_wr(2'd0, 8'h11);
    bus_wr(2'd0, 8'h22);
    wait_idle();
    bus_rd(2'd2, s); chk("R6 overrun flagged", s, 8'h07);
    bus_rd(2'd0, d); chk("R6 old byte kept", d, 8'h11);
    bus_rd(2'd2, s); chk("R6 flags cleared", s, 8'h02);
    // R7 repeat, CPOL=1 CPHA=0
    bus_wr(2'd1, 8'h42);
    bus_wr(2'd0, 8'hC3);
    bus_wr(2'd1, 8'h43);
    repeat (100) cyc();
    bus_wr(2'd1, 8'h03);
    wait_idle();
    bus_rd(2'd2, s); chk("R7 repeated transfers overran", s, 8'h07);
    bus_rd(2'd0, d); chk("R7 repeated byte", d, 8'hC3);
    bus_rd(2'd2, s); chk("R7 flags cleared", s, 8'h02);
    // R8 mode fault
    bus_wr(2'd1, 8'h21);
    ss_n = 1'b0;
    repeat (4) cyc();
    bus_rd(2'd1, s); chk("R8 enable dropped", s, 8'h20);
    chk("R10 error irq on mode fault", irq_rxe, 1);
    bus_wr(2'd1, 8'h21);
    bus_rd(2'd1, s); chk("R8 enable refused while fault", s, 8'h20);
    ss_n = 1'b1;
    repeat (3) cyc();
    bus_rd(2'd2, s); chk("R8 mode fault flagged", s, 8'h0A);
    bus_wr(2'd1, 8'h21);
    bus_rd(2'd1, s); chk("R8 enable after clear", s, 8'h21);
    bus_rd(2'd2, s); chk("R8 mode fault cleared", s, 8'h02);
    repeat (4) cyc();
    finish_run();
  end
endmodule